// File: doc/BRIEF.md
# Three-Wire Serial Control Register Receiver

This block receives write-only control traffic over three wires (a data line, a mode line and a serial clock) and keeps the settings of an audio processing path in parallel registers. All three wires are brought into the system clock domain through two-flop synchronizers. Bits are captured on detected rising edges of the serial clock, least significant bit first, in groups of eight.

A byte sent while the mode line is low is an address byte. Its upper six bits must match the device address. Its lower two bits then pick one of two register groups. Bytes sent with the mode line high are data bytes. They go to the group that was last picked, for as many bytes as follow, until another address byte arrives. Inside the level group, the top two bits of each data byte choose the register. A status byte carries the tone mode, the de-emphasis enable and both channel selectors together.

Top module: `ctrl3w_rx`

## Requirements
- R1: After reset both volumes, bass, treble and tone mode are 0, de-emphasis is 0, the left selector is 2'b10 and the right selector is 2'b01.
- R2: A byte is assembled LSB first from the first serial bit. A byte completed with the mode line low is an address byte. It matches when its bits 7..2 equal 6'b000101, and an address byte never changes any output register.
- R3: After an address byte whose bits 7..2 differ from 6'b000101, the data bytes that follow change no output register.
- R4: A matching address byte with bits 1..0 = 2'b00 selects the level group and 2'b10 selects the status group; 2'b01 and 2'b11 select nothing, so the data bytes that follow are ignored.
- R5: A group selection stays in force for any number of consecutive data bytes, until the next address byte.
- R6: In the level group, data bits 7..6 select the target: 2'b00 writes bits 5..0 to the right volume, 2'b01 writes bits 5..0 to the left volume, 2'b10 writes bits 4..0 to bass and 2'b11 writes bits 4..0 to treble; bit 5 is ignored for bass and treble.
- R7: In the status group, a byte with bit 7 = 0 loads tone mode from bits 6..5, de-emphasis from bit 4, the right selector from bits 3..2 and the left selector from bits 1..0. A byte with bit 7 = 1 is ignored.
- R8: A byte takes effect only once its eighth bit has been captured. Any change of the mode line discards a partly received byte and restarts the bit count.
- R9: Output registers change only in the cycle after a completed data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_data_i | input | 1 | Serial data line |
| ctl_mode_i | input | 1 | Mode line: low = address, high = data |
| ctl_clk_i | input | 1 | Serial clock line; bits are taken on its rising edge |
| vol_right_o | output | 6 | Right volume attenuation code |
| vol_left_o | output | 6 | Left volume attenuation code |
| bass_o | output | 5 | Bass boost code |
| treble_o | output | 5 | Treble code |
| tone_mode_o | output | 2 | Tone filter mode |
| deemph_o | output | 1 | De-emphasis enable |
| sel_right_o | output | 2 | Right channel source selector |
| sel_left_o | output | 2 | Left channel source selector |

## Verification
The assertions assume that the serial lines change much more slowly than the system clock. Each serial clock level and each data value must hold for several system cycles, so that every rising edge survives the synchronizers as one clean edge, with the data already settled. The stimulus holds every level for at least four system cycles. It sets data and mode well before the serial clock rises, and it changes the mode line only while the serial clock is low. The one exception is the deliberate mode toggle in the middle of a byte, which tests that a partial byte is discarded.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;
    localparam int VOL_W  = 6;
    localparam int TONE_W = 5;
    localparam int SEL_W  = 2;
    localparam int SYNC_STAGES = 2;
    localparam logic [ADDR_W-1:0] DEV_ADDR = 6'b000101;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_LVL  = 2'd1,
        GRP_STAT = 2'd2
    } grp_e;

    typedef struct packed {
        logic [VOL_W-1:0]  vol_r;
        logic [VOL_W-1:0]  vol_l;
        logic [TONE_W-1:0] bass;
        logic [TONE_W-1:0] treb;
        logic [1:0]        tmode;
        logic              deemph;
        logic [SEL_W-1:0]  sel_r;
        logic [SEL_W-1:0]  sel_l;
    } ctl_regs_t;

    localparam ctl_regs_t REGS_RST = '{
        vol_r: '0, vol_l: '0, bass: '0, treb: '0,
        tmode: 2'b00, deemph: 1'b0, sel_r: 2'b01, sel_l: 2'b10
    };
endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ctrl3w_shift.sv
module ctrl3w_shift
    import ctrl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_clk,
    input  logic              s_mode,
    input  logic              s_data,
    output logic              byte_vld,
    output logic              byte_is_addr,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              clk_prev;
        logic              mode_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              vld;
        logic              is_addr;
        logic [BYTE_W-1:0] out;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        sh_d           = sh_q;
        sh_d.vld       = 1'b0;
        sh_d.clk_prev  = s_clk;
        sh_d.mode_prev = s_mode;
        shifted        = {s_data, sh_q.shreg[BYTE_W-1:1]};
        if (s_mode != sh_q.mode_prev) begin
            sh_d.cnt = '0;
        end else if (s_clk && !sh_q.clk_prev) begin
            sh_d.shreg = shifted;
            if (sh_q.cnt == LAST_BIT) begin
                sh_d.cnt     = '0;
                sh_d.vld     = 1'b1;
                sh_d.out     = shifted;
                sh_d.is_addr = !s_mode;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign byte_vld     = sh_q.vld;
    assign byte_is_addr = sh_q.is_addr;
    assign byte_val     = sh_q.out;
endmodule

// File: rtl/ctrl3w_regs.sv
module ctrl3w_regs
    import ctrl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_is_addr,
    input  logic [BYTE_W-1:0] byte_val,
    output grp_e              grp,
    output ctl_regs_t         regs
);
    typedef struct packed {
        grp_e      grp;
        ctl_regs_t regs;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (byte_vld) begin
            if (byte_is_addr) begin
                rf_d.grp = GRP_NONE;
                if (byte_val[BYTE_W-1:BYTE_W-ADDR_W] == DEV_ADDR) begin
                    case (byte_val[1:0])
                        2'b00:   rf_d.grp = GRP_LVL;
                        2'b10:   rf_d.grp = GRP_STAT;
                        default: rf_d.grp = GRP_NONE;
                    endcase
                end
            end else begin
                case (rf_q.grp)
                    GRP_LVL: begin
                        case (byte_val[7:6])
                            2'b00: rf_d.regs.vol_r = byte_val[VOL_W-1:0];
                            2'b01: rf_d.regs.vol_l = byte_val[VOL_W-1:0];
                            2'b10: rf_d.regs.bass  = byte_val[TONE_W-1:0];
                            2'b11: rf_d.regs.treb  = byte_val[TONE_W-1:0];
                            default: ;
                        endcase
                    end
                    GRP_STAT: begin
                        if (!byte_val[7]) begin
                            rf_d.regs.tmode  = byte_val[6:5];
                            rf_d.regs.deemph = byte_val[4];
                            rf_d.regs.sel_r  = byte_val[3:2];
                            rf_d.regs.sel_l  = byte_val[1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.grp  <= GRP_NONE;
            rf_q.regs <= REGS_RST;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign grp  = rf_q.grp;
    assign regs = rf_q.regs;
endmodule

// File: rtl/ctrl3w_rx.sv
module ctrl3w_rx
    import ctrl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_data_i,
    input  logic              ctl_mode_i,
    input  logic              ctl_clk_i,
    output logic [VOL_W-1:0]  vol_right_o,
    output logic [VOL_W-1:0]  vol_left_o,
    output logic [TONE_W-1:0] bass_o,
    output logic [TONE_W-1:0] treble_o,
    output logic [1:0]        tone_mode_o,
    output logic              deemph_o,
    output logic [SEL_W-1:0]  sel_right_o,
    output logic [SEL_W-1:0]  sel_left_o
);
    logic [2:0]        s_lines;
    logic              s_clk, s_mode, s_data;
    logic              byte_vld, byte_is_addr;
    logic [BYTE_W-1:0] byte_val;
    grp_e              cur_grp;
    ctl_regs_t         regs_q;

    ctrl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ctl_clk_i, ctl_mode_i, ctl_data_i}),
        .dout (s_lines)
    );

    assign s_clk  = s_lines[2];
    assign s_mode = s_lines[1];
    assign s_data = s_lines[0];

    ctrl3w_shift shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_clk       (s_clk),
        .s_mode      (s_mode),
        .s_data      (s_data),
        .byte_vld    (byte_vld),
        .byte_is_addr(byte_is_addr),
        .byte_val    (byte_val)
    );

    ctrl3w_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (byte_vld),
        .byte_is_addr(byte_is_addr),
        .byte_val    (byte_val),
        .grp         (cur_grp),
        .regs        (regs_q)
    );

    assign vol_right_o = regs_q.vol_r;
    assign vol_left_o  = regs_q.vol_l;
    assign bass_o      = regs_q.bass;
    assign treble_o    = regs_q.treb;
    assign tone_mode_o = regs_q.tmode;
    assign deemph_o    = regs_q.deemph;
    assign sel_right_o = regs_q.sel_r;
    assign sel_left_o  = regs_q.sel_l;
endmodule

// File: rtl/ctrl3w_chk.sv
module ctrl3w_chk
    import ctrl3w_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      s_clk,
    input logic      byte_vld,
    input logic      byte_is_addr,
    input grp_e      grp,
    input ctl_regs_t regs
);
    // R9: without a completed byte, the registers hold
    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(regs));

    // R2: an address byte writes nothing
    assert_addr_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_addr) |=> $stable(regs));

    // R3 and R4: data bytes are ignored while no group is selected
    assert_desel_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_is_addr && grp == GRP_NONE) |=> $stable(regs));

    // R5: the selection changes only on an address byte
    assert_grp_persist_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && byte_is_addr) |=> $stable(grp));

    // R8: a completed byte follows a captured serial clock edge
    assert_commit_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(s_clk));

    // R8: one strobe per byte
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

bind ctrl3w_rx ctrl3w_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_clk       (s_clk),
    .byte_vld    (byte_vld),
    .byte_is_addr(byte_is_addr),
    .grp         (cur_grp),
    .regs        (regs_q)
);

// File: tb/ctrl3w_rx_tb_top.sv
module ctrl3w_rx_tb_top;
    import ctrl3w_pkg::*;

    typedef struct {
        ctl_regs_t exp;
        string     tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_data_i = 1'b0;
    logic ctl_mode_i = 1'b0;
    logic ctl_clk_i = 1'b0;
    logic [VOL_W-1:0]  vol_right_o, vol_left_o;
    logic [TONE_W-1:0] bass_o, treble_o;
    logic [1:0]        tone_mode_o;
    logic              deemph_o;
    logic [SEL_W-1:0]  sel_right_o, sel_left_o;

    int n_total = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t exp_q[$];
    ctl_regs_t m_regs;
    int m_grp;

    always #10 clk = ~clk;

    ctrl3w_rx dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_data_i(ctl_data_i), .ctl_mode_i(ctl_mode_i), .ctl_clk_i(ctl_clk_i),
        .vol_right_o(vol_right_o), .vol_left_o(vol_left_o),
        .bass_o(bass_o), .treble_o(treble_o), .tone_mode_o(tone_mode_o),
        .deemph_o(deemph_o), .sel_right_o(sel_right_o), .sel_left_o(sel_left_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        if (ctl_mode_i != m) begin
            ctl_mode_i = m;
            wait_cyc(6);
        end
    endtask

    task automatic send_bit(input logic b);
        ctl_data_i = b;
        wait_cyc(4);
        ctl_clk_i = 1'b1;
        wait_cyc(4);
        ctl_clk_i = 1'b0;
        wait_cyc(4);
    endtask

    // expected behaviour from the requirements
    function automatic void model_byte(input logic is_addr, input logic [7:0] b);
        if (is_addr) begin
            m_grp = 0;
            if (b[7:2] == 6'b000101 && b[1:0] == 2'b00) m_grp = 1;
            if (b[7:2] == 6'b000101 && b[1:0] == 2'b10) m_grp = 2;
        end else if (m_grp == 1) begin
            case (b[7:6])
                2'b00: m_regs.vol_r = b[5:0];
                2'b01: m_regs.vol_l = b[5:0];
                2'b10: m_regs.bass  = b[4:0];
                default: m_regs.treb = b[4:0];
            endcase
        end else if (m_grp == 2 && !b[7]) begin
            m_regs.tmode  = b[6:5];
            m_regs.deemph = b[4];
            m_regs.sel_r  = b[3:2];
            m_regs.sel_l  = b[1:0];
        end
    endfunction

    task automatic push_chk(input string tag);
        item_t it;
        wait_cyc(8);
        it.exp = m_regs;
        it.tag = tag;
        exp_q.push_back(it);
        wait_cyc(1);
    endtask

    task automatic send_byte(input logic is_addr, input logic [7:0] b, input string tag);
        set_mode(!is_addr);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        model_byte(is_addr, b);
        push_chk(tag);
    endtask

    // monitor: pops expected snapshots and compares with the outputs
    initial begin
        forever begin
            item_t it;
            ctl_regs_t act;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            act = '{vol_r: vol_right_o, vol_l: vol_left_o, bass: bass_o, treb: treble_o,
                    tmode: tone_mode_o, deemph: deemph_o, sel_r: sel_right_o, sel_l: sel_left_o};
            n_total++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        m_regs = '{vol_r: '0, vol_l: '0, bass: '0, treb: '0,
                   tmode: 2'b00, deemph: 1'b0, sel_r: 2'b01, sel_l: 2'b10};
        m_grp = 0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        push_chk("R1 reset values");
        send_byte(1'b0, 8'h15, "R3 data byte before any address ignored");
        send_byte(1'b1, 8'h14, "R2 address byte selects level group, no write");
        send_byte(1'b0, 8'h2A, "R6 right volume");
        send_byte(1'b0, 8'h45, "R5 R6 left volume");
        send_byte(1'b0, 8'hBF, "R6 bass with bit5 ignored");
        send_byte(1'b0, 8'hE3, "R6 treble");
        send_byte(1'b1, 8'h16, "R2 status group address");
        send_byte(1'b0, 8'h5B, "R7 status fields");
        send_byte(1'b0, 8'hC0, "R7 status byte with bit7 set ignored");
        send_byte(1'b0, 8'h27, "R5 R7 second status byte");
        send_byte(1'b1, 8'h15, "R4 unused type 01");
        send_byte(1'b0, 8'h00, "R4 data after type 01 ignored");
        send_byte(1'b1, 8'h17, "R4 unused type 11");
        send_byte(1'b0, 8'h40, "R4 data after type 11 ignored");
        send_byte(1'b1, 8'h24, "R3 mismatched address");
        send_byte(1'b0, 8'h00, "R3 data after mismatch ignored");
        send_byte(1'b1, 8'h14, "R2 reselect level group");
        // R8: partial byte discarded by a mode toggle
        set_mode(1'b1);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        set_mode(1'b0);
        set_mode(1'b1);
        push_chk("R8 partial byte discarded");
        send_byte(1'b0, 8'h01, "R8 full byte after discard");
        // R8: nothing before the eighth bit
        for (int i = 0; i < 7; i++) send_bit(i == 0 || i == 2);
        push_chk("R8 seven bits commit nothing");
        send_bit(1'b0);
        model_byte(1'b0, 8'h05);
        push_chk("R8 eighth bit commits");
        wait (exp_q.size() == 0);
        wait_cyc(2);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule